// File: doc/BRIEF.md
# Ethernet Transmit Frame Unpacker

The block sits between a 32-bit transmit FIFO and the byte-wide input of a MAC transmit datapath. Software writes each frame into the FIFO in a fixed word layout. The first word holds a little-endian 16-bit payload length in its two low byte lanes and the first two destination octets in its two high lanes. The next three words hold the rest of the destination address, the source address and the length/type field. The payload follows, four octets per word. The block takes these words one at a time and turns them into a byte stream, lowest byte lane first, on a valid/ready interface.

The length prefix counts payload bytes only. Byte lanes beyond the payload in the final payload word are dropped. Pad enable and CRC enable are sampled when a frame's first word is accepted. With pad enable set, a payload shorter than 46 bytes is extended with zero bytes up to 46. With CRC enable set, the block computes the reflected CRC-32 over every byte from the first destination octet through the padding and sends it least significant byte first. With CRC enable clear, it fetches one more FIFO word and sends that word unchanged as the frame check sequence, which lets software send frames with a deliberately wrong checksum. The final byte of each frame carries a last marker. The block then goes idle and only begins a new frame while transmit enable is high.

Top module: `eth_tx_unpacker`

## Requirements
- R1: While the block is idle and `tx_en` is low, `fifo_ready` stays low and `out_valid` stays low, so no word is taken and no byte is offered. After reset the block is idle.
- R2: In the first FIFO word, bits 7:0 are the payload length low byte and bits 15:8 are the high byte. Bits 23:16 and then bits 31:24 are sent as the first two bytes of the frame.
- R3: The second, third and fourth words are each sent as four bytes starting at bits 7:0, giving destination octets 3 to 6, source octets 1 to 6 and the length/type field.
- R4: Payload words follow, sent lowest lane first. Exactly `length` payload bytes are sent, and the unused upper lanes of the last payload word are discarded.
- R5: When pad enable is latched and the length is below 46, 46 minus length zero bytes follow the payload. Otherwise no pad byte is sent. The frame then has 14 + max(payload, padded size) + 4 bytes.
- R6: When CRC enable is latched, the four bytes after the payload and padding are the ones' complement of the reflected CRC-32 (polynomial 0xEDB88320 in reflected form, preset all ones) over all earlier frame bytes, least significant byte first.
- R7: When CRC enable is clear, one more FIFO word is taken after the payload and sent unchanged as the last four bytes, bits 7:0 first.
- R8: `out_last` is high with the final byte of the frame and with no other byte. After that byte is accepted the block is idle and takes the next frame's first word.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. No byte is lost or repeated under back-pressure, and no FIFO word is taken while a byte is offered.
- R10: Changing `pad_en` or `crc_en` after a frame's first word has been accepted has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Allows a new frame to start |
| crc_en | input | 1 | Generate and append the FCS |
| pad_en | input | 1 | Pad short payloads to 46 bytes |
| fifo_data | input | 32 | Word at the head of the transmit FIFO |
| fifo_valid | input | 1 | FIFO head word is present |
| fifo_ready | output | 1 | Block takes the head word this cycle |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte is offered |
| out_ready | input | 1 | Downstream accepts the byte |
| out_last | output | 1 | Offered byte ends the frame |

## Verification
An off-by-one in the lane or remaining-byte counters shows up at the ports within the same word. A payload byte is duplicated or dropped, and every later byte, the checksum and the last marker shift with it, so the frame length check and the FCS comparison fail on that frame. A wrong CRC register value is seen only in the four checksum bytes at the end of the frame, so each frame length with CRC enabled compares those bytes against an independent checksum. A stuck frame state shows as a missing last marker or as FIFO words left untaken, and the next frame in the back-to-back sequence arrives corrupted.

// File: rtl/etu_pkg.sv
package etu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_EMIT = 3'd2,
    ST_PAD  = 3'd3,
    ST_FCS  = 3'd4
  } etu_state_e;

  typedef enum logic [1:0] {
    SEG_HDR   = 2'd0,
    SEG_PAY   = 2'd1,
    SEG_SWFCS = 2'd2
  } etu_seg_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
endpackage

// File: rtl/etu_crc32_step.sv
module etu_crc32_step #(
  parameter logic [31:0] POLY = 32'hEDB8_8320
) (
  input  logic [31:0] crc_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  always_comb begin
    logic [31:0] c;
    c = crc_i ^ {24'h0, data_i};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
    end
    crc_o = c;
  end
endmodule

// File: rtl/etu_lane_pick.sv
module etu_lane_pick #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0]         word_i,
  input  logic [$clog2(LANES)-1:0]   sel_i,
  output logic [7:0]                 byte_o
);
  logic [7:0] lane_bytes [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = word_i[g*8 +: 8];
  end
  assign byte_o = lane_bytes[sel_i];
endmodule

// File: rtl/eth_tx_unpacker.sv
module eth_tx_unpacker
  import etu_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MIN_PAY   = 46,
  parameter int HDR_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              crc_en,
  input  logic              pad_en,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last
);
  localparam int LANES     = WORD_W / 8;
  localparam int LANE_W    = $clog2(LANES);
  localparam int HDR_CW    = $clog2(HDR_WORDS);
  localparam int LEN_BYTES = LEN_W / 8;

  etu_state_e        state_q, state_d;
  etu_seg_e          seg_q, seg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [LANE_W-1:0] lane_end_q, lane_end_d;
  logic [HDR_CW-1:0] hdr_left_q, hdr_left_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  pad_left_q, pad_left_d;
  logic              pad_go_q, pad_go_d;
  logic              crc_go_q, crc_go_d;
  logic [31:0]       crc_q, crc_d;

  logic [WORD_W-1:0] pick_word;
  logic [7:0]        pick_byte;
  logic [7:0]        crc_byte;
  logic [31:0]       crc_next;
  logic [LEN_W-1:0]  first_len;

  assign pick_word = (state_q == ST_FCS) ? WORD_W'(~crc_q) : word_q;
  assign crc_byte  = (state_q == ST_PAD) ? 8'h00 : pick_byte;
  assign first_len = fifo_data[LEN_W-1:0];

  etu_lane_pick #(.LANES(LANES)) u_pick (
    .word_i (pick_word),
    .sel_i  (lane_q),
    .byte_o (pick_byte)
  );

  etu_crc32_step #(.POLY(CRC_POLY_REFL)) u_crc (
    .crc_i  (crc_q),
    .data_i (crc_byte),
    .crc_o  (crc_next)
  );

  // next-state logic
  always_comb begin
    logic go_tail, go_fcs;
    state_d    = state_q;
    seg_d      = seg_q;
    word_d     = word_q;
    lane_d     = lane_q;
    lane_end_d = lane_end_q;
    hdr_left_d = hdr_left_q;
    rem_d      = rem_q;
    pad_left_d = pad_left_q;
    pad_go_d   = pad_go_q;
    crc_go_d   = crc_go_q;
    crc_d      = crc_q;
    fifo_ready = 1'b0;
    out_valid  = 1'b0;
    out_last   = 1'b0;
    out_data   = pick_byte;
    go_tail    = 1'b0;
    go_fcs     = 1'b0;

    case (state_q)
      ST_IDLE: begin
        fifo_ready = tx_en;
        if (tx_en && fifo_valid) begin
          word_d     = fifo_data;
          lane_d     = LANE_W'(LEN_BYTES);
          lane_end_d = LANE_W'(LANES - 1);
          seg_d      = SEG_HDR;
          hdr_left_d = HDR_CW'(HDR_WORDS - 1);
          rem_d      = first_len;
          pad_go_d   = pad_en && (first_len < LEN_W'(MIN_PAY));
          pad_left_d = LEN_W'(MIN_PAY) - first_len;
          crc_go_d   = crc_en;
          crc_d      = '1;
          state_d    = ST_EMIT;
        end
      end
      ST_LOAD: begin
        fifo_ready = 1'b1;
        if (fifo_valid) begin
          word_d  = fifo_data;
          lane_d  = '0;
          state_d = ST_EMIT;
          if (seg_q == SEG_PAY && rem_q < LEN_W'(LANES))
            lane_end_d = LANE_W'(rem_q - 1'b1);
          else
            lane_end_d = LANE_W'(LANES - 1);
        end
      end
      ST_EMIT: begin
        out_valid = 1'b1;
        out_last  = (seg_q == SEG_SWFCS) && (lane_q == lane_end_q);
        if (out_ready) begin
          if (seg_q != SEG_SWFCS) crc_d = crc_next;
          if (seg_q == SEG_PAY)   rem_d = rem_q - 1'b1;
          if (lane_q != lane_end_q) begin
            lane_d = lane_q + 1'b1;
          end else begin
            case (seg_q)
              SEG_HDR: begin
                if (hdr_left_q != '0) begin
                  hdr_left_d = hdr_left_q - 1'b1;
                  state_d    = ST_LOAD;
                end else if (rem_q != '0) begin
                  seg_d   = SEG_PAY;
                  state_d = ST_LOAD;
                end else begin
                  go_tail = 1'b1;
                end
              end
              SEG_PAY: begin
                if (rem_q == LEN_W'(1)) go_tail = 1'b1;
                else                    state_d = ST_LOAD;
              end
              default: state_d = ST_IDLE;
            endcase
          end
        end
      end
      ST_PAD: begin
        out_valid = 1'b1;
        out_data  = 8'h00;
        if (out_ready) begin
          crc_d      = crc_next;
          pad_left_d = pad_left_q - 1'b1;
          if (pad_left_q == LEN_W'(1)) go_fcs = 1'b1;
        end
      end
      ST_FCS: begin
        out_valid = 1'b1;
        out_last  = (lane_q == LANE_W'(LANES - 1));
        if (out_ready) begin
          if (out_last) state_d = ST_IDLE;
          else          lane_d  = lane_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (go_tail) begin
      if (pad_go_q) state_d = ST_PAD;
      else          go_fcs  = 1'b1;
    end
    if (go_fcs) begin
      if (crc_go_q) begin
        state_d = ST_FCS;
        lane_d  = '0;
      end else begin
        seg_d   = SEG_SWFCS;
        state_d = ST_LOAD;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      seg_q      <= SEG_HDR;
      word_q     <= '0;
      lane_q     <= '0;
      lane_end_q <= '0;
      hdr_left_q <= '0;
      rem_q      <= '0;
      pad_left_q <= '0;
      pad_go_q   <= 1'b0;
      crc_go_q   <= 1'b0;
      crc_q      <= '1;
    end else begin
      state_q    <= state_d;
      seg_q      <= seg_d;
      word_q     <= word_d;
      lane_q     <= lane_d;
      lane_end_q <= lane_end_d;
      hdr_left_q <= hdr_left_d;
      rem_q      <= rem_d;
      pad_left_q <= pad_left_d;
      pad_go_q   <= pad_go_d;
      crc_go_q   <= crc_go_d;
      crc_q      <= crc_d;
    end
  end
endmodule

// File: rtl/etu_checker.sv
module etu_checker
  import etu_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       fifo_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_last,
  input etu_state_e state_q
);
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !tx_en) |-> !fifo_ready); // R1
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !out_valid); // R1
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9
  AST_NO_POP_DURING_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !fifo_ready); // R9
  AST_LAST_ONLY_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R8
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (state_q == ST_IDLE && !out_valid)); // R8
endmodule

bind eth_tx_unpacker etu_checker u_etu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .fifo_ready (fifo_ready),
  .out_data   (out_data),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_last   (out_last),
  .state_q    (state_q)
);

// File: tb/test_eth_tx_unpacker.sv
module test_eth_tx_unpacker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_en, crc_en, pad_en;
  logic [31:0] fifo_data;
  logic        fifo_valid;
  logic        fifo_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready;
  logic        out_last;

  eth_tx_unpacker i_eth_tx_unpacker (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .crc_en(crc_en), .pad_en(pad_en),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last)
  );

  always #2 clk = ~clk;

  int          total = 0;
  int          fails = 0;
  int          cyc = 0;
  logic [31:0] fq[$];
  logic [7:0]  cap [0:299];
  logic [7:0]  exp_b [0:299];
  int          ncap = 0;
  int          lastcnt = 0;
  int          lastpos = -1;
  bit          in_take;
  bit          stall_mode = 1'b0;

  // vector: {len[15:0], pad, crc, stall, flip}
  localparam int NVEC = 10;
  localparam logic [19:0] VEC [NVEC] = '{
    {16'd46, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'd0,  1'b1, 1'b1, 1'b0, 1'b0},
    {16'd5,  1'b1, 1'b1, 1'b1, 1'b0},
    {16'd47, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'd10, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'd7,  1'b1, 1'b0, 1'b0, 1'b0},
    {16'd61, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    {16'd3,  1'b1, 1'b1, 1'b1, 1'b1},
    {16'd50, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      check(1'b0, "WATCHDOG", "run did not finish", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", total, fails);
      $finish;
    end
  end

  // FIFO driver and output monitor: sample at negedge, drive after posedge
  always begin
    @(negedge clk);
    in_take = fifo_valid && fifo_ready;
    if (out_valid && out_ready && ncap < 300) begin
      cap[ncap] = out_data;
      if (out_last) begin
        lastcnt++;
        lastpos = ncap;
      end
      ncap++;
    end
    @(posedge clk);
    #1;
    if (in_take && fq.size() > 0) void'(fq.pop_front());
    fifo_valid = (fq.size() != 0);
    fifo_data  = (fq.size() != 0) ? fq[0] : 32'h0;
    out_ready  = !(stall_mode && (cyc % 3 == 0));
  end

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ exp_b[i][b]) c = (c >> 1) ^ 32'hEDB8_8320;
        else                    c = c >> 1;
      end
    end
    return ~c;
  endfunction

  task automatic region(input int lo, input int hi, input string tag, input string what);
    int bad;
    bad = -1;
    for (int i = lo; i < hi; i++) if (bad < 0 && cap[i] !== exp_b[i]) bad = i;
    if (bad < 0) check(1'b1, tag, what, 0, 0);
    else check(1'b0, tag, $sformatf("%s byte %0d", what, bad), cap[bad], exp_b[bad]);
  endtask

  task automatic run_frame(input int len, input bit pad, input bit crc,
                           input bit stall, input bit flip);
    logic [7:0]  hdr [14];
    logic [31:0] w;
    logic [31:0] fcs;
    int padn, n, pw, wait_c;
    for (int i = 0; i < 14; i++) hdr[i] = 8'(8'h21 + i * 5 + len);
    padn = (pad && len < 46) ? 46 - len : 0;
    n = 0;
    for (int i = 0; i < 14; i++) begin exp_b[n] = hdr[i]; n++; end
    for (int i = 0; i < len; i++) begin exp_b[n] = 8'(i * 7 + 3 + len); n++; end
    for (int i = 0; i < padn; i++) begin exp_b[n] = 8'h00; n++; end
    if (crc) fcs = ref_crc(n);
    else     fcs = 32'hC0FF_EE12 ^ len;
    for (int i = 0; i < 4; i++) begin exp_b[n] = fcs[i*8 +: 8]; n++; end

    @(posedge clk); #1;
    ncap = 0; lastcnt = 0; lastpos = -1;
    pad_en = pad; crc_en = crc; stall_mode = stall;
    fq.push_back({hdr[1], hdr[0], 8'(len >> 8), 8'(len)});
    fq.push_back({hdr[5], hdr[4], hdr[3], hdr[2]});
    fq.push_back({hdr[9], hdr[8], hdr[7], hdr[6]});
    fq.push_back({hdr[13], hdr[12], hdr[11], hdr[10]});
    pw = (len + 3) / 4;
    for (int k = 0; k < pw; k++) begin
      for (int j = 0; j < 4; j++)
        w[j*8 +: 8] = (k * 4 + j < len) ? 8'((k * 4 + j) * 7 + 3 + len) : 8'hAA;
      fq.push_back(w);
    end
    if (!crc) fq.push_back(fcs);

    wait_c = 0;
    while (lastcnt == 0 && wait_c < 3000) begin
      @(posedge clk); #1;
      wait_c++;
      if (flip && ncap > 0) begin pad_en = !pad; crc_en = !crc; end
    end
    repeat (3) @(posedge clk);
    #1;
    pad_en = pad; crc_en = crc;

    check(ncap == n, "R5", $sformatf("frame length (len %0d)", len), ncap, n);
    region(0, 2, "R2", "first destination octets");
    region(2, 14, "R3", "header words");
    region(14, 14 + len, "R4", "payload");
    if (padn > 0) region(14 + len, 14 + len + padn, "R5", "pad bytes");
    if (crc) region(n - 4, n, "R6", "generated FCS");
    else     region(n - 4, n, "R7", "software FCS");
    check(lastcnt == 1 && lastpos == n - 1, "R8", "last marker position", lastpos, n - 1);
    check(fq.size() == 0, "R4", "all FIFO words consumed", fq.size(), 0);
    if (stall) check(ncap == n, "R9", "no loss under back-pressure", ncap, n);
    if (flip)  region(0, n, "R10", "enables latched at frame start");
  endtask

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; crc_en = 1'b1; pad_en = 1'b1;
    fifo_valid = 1'b0; fifo_data = 32'h0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(fifo_ready == 1'b0, "R1", "fifo_ready in reset", fifo_ready, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // transmit disabled: a queued word must stay in the FIFO
    fq.push_back(32'h1122_0004);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(fq.size() == 1, "R1", "word held while tx_en low", fq.size(), 1);
    check(ncap == 0 && out_valid == 1'b0, "R1", "no byte while tx_en low", ncap, 0);
    @(posedge clk); #1;
    fq.delete();
    fifo_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    tx_en = 1'b1;

    for (int v = 0; v < NVEC; v++)
      run_frame(int'(VEC[v][19:4]), VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);

    // back-to-back boundary: payload of exactly one word, no pad, generated FCS
    run_frame(4, 1'b0, 1'b1, 1'b0, 1'b0);
    // payload ending on lane 0 of its last word with software FCS
    run_frame(1, 1'b0, 1'b0, 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end
endmodule